// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block is the byte queue that sits behind a storage controller's FIFO register when data moves by programmed I/O. The host pushes bytes through a write port and pulls them through a read port. A signed residual count tracks how many bytes are held. The read and write pointers both return to slot zero whenever they become equal. Because a write is refused while the write pointer sits on the last slot, the queue holds one byte fewer than its storage.

While a selection sequence is gathering command-descriptor bytes, the host raises a capture input. Writes then go to a separate, larger command buffer, and the data queue is left untouched. The captured bytes can be read back by index. When a command finishes under programmed I/O, a single pulse preloads the queue with the status byte followed by a zero message byte. Starting a new selection empties both stores. A write refused by either store raises a sticky overrun flag, which stays set until a flush request or a reset.

Top module: `pio_fifo_cmdcap`

## Requirements
- R1: With capture off, an accepted write stores `wr_data` and raises `residual` and `fill_level` by one. A write and a read in the same cycle leave `residual` unchanged and both take effect.
- R2: A write while the write pointer equals BUF_DEPTH-1 is dropped and sets `overrun`. With the default depth, at most 15 bytes are held.
- R3: A read while `bus_phase` is 3'b000 (data-out) sets `rd_data` to 0x00 after the clock edge and removes nothing.
- R4: A read with a nonzero `bus_phase` and data held presents the oldest byte on `rd_data` after the edge and lowers `residual` by one. A read with nothing held leaves `rd_data` and `residual` unchanged.
- R5: When the read and write pointers meet, both return to zero, so a drained queue again accepts BUF_DEPTH-1 bytes without overrun.
- R6: A `status_load` pulse makes the queue hold `status_byte` and then 0x00, with `residual` and `fill_level` equal to 2. A write or read in the same cycle is ignored.
- R7: A `sel_start` pulse clears `residual`, both pointers and `cmd_len`. A write or read in the same cycle is ignored, and `rd_data` keeps its value.
- R8: With `capture_mode` high, writes are stored in the command buffer at index `cmd_len`, `cmd_len` increments, and `residual` does not change. `cmd_rd_data` shows the entry at `cmd_rd_idx` combinationally.
- R9: Once `cmd_len` equals CMD_DEPTH (32 by default), further capture writes are dropped, `cmd_len` holds, and `overrun` is set.
- R10: `overrun` stays set until a `flush` cycle with no drop. A drop in the same cycle as `flush` leaves it set.
- R11: After reset, `residual`, `fill_level`, `cmd_len`, `overrun` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Host byte read strobe |
| bus_phase | input | 3 | Current bus phase bits; 3'b000 means data-out |
| capture_mode | input | 1 | Route writes to the command buffer |
| sel_start | input | 1 | New selection: empty both stores |
| status_load | input | 1 | Preload status byte and zero message byte |
| status_byte | input | 8 | Status byte for preload |
| flush | input | 1 | Clear the overrun flag |
| cmd_rd_idx | input | 5 | Command buffer read index |
| rd_data | output | 8 | Last byte read (registered) |
| residual | output | 6 | Signed residual byte count |
| fill_level | output | 5 | Bytes between read and write pointers |
| overrun | output | 1 | Sticky dropped-byte flag |
| cmd_len | output | 6 | Bytes captured in the command buffer |
| cmd_rd_data | output | 8 | Command buffer entry at `cmd_rd_idx` |

## Verification
Two pairs of functions can land in the same cycle. A write can coincide with a read, and a refused write can coincide with a flush. The bench provokes the first pair by raising `wr_en` and `rd_en` together while bytes are held. It then expects the oldest byte on `rd_data` and an unchanged `residual`, and the newly written byte must emerge later in order. The second pair is provoked by writing into a full queue while `flush` is high. `overrun` is judged to stay set, and it must drop only on a later flush with no drop.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

    localparam int BYTE_W  = 8;
    localparam int PHASE_W = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    // message byte that follows the status byte on a preload
    localparam byte_t MSG_FILL = '0;

    // one cycle of requests toward the data queue
    typedef struct packed {
        logic  clear;
        logic  load_sts;
        logic  push;
        logic  pop;
        logic  zero_rd;
        byte_t wdata;
        byte_t sts;
    } fifo_req_t;

    function automatic logic phase_is_out(input logic [PHASE_W-1:0] ph);
        return ph == '0;
    endfunction

endpackage

// File: rtl/pcf_data_fifo.sv
module pcf_data_fifo
    import pcf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  fifo_req_t            req,
    output byte_t                rd_byte,
    output logic [PW-1:0]        rd_ptr,
    output logic [PW-1:0]        wr_ptr,
    output logic signed [CW-1:0] residual,
    output logic                 drop
);

    byte_t                 mem [DEPTH];
    logic                  push_ok, pop_ok;
    logic [PW-1:0]         nxt_r, nxt_w;
    logic signed [CW-1:0]  delta;

    always_comb begin
        push_ok = req.push && (wr_ptr != PW'(DEPTH - 1));
        pop_ok  = req.pop && (rd_ptr < wr_ptr);
        drop    = req.push && !push_ok;
        nxt_r   = rd_ptr + PW'(pop_ok);
        nxt_w   = wr_ptr + PW'(push_ok);
        if (nxt_r == nxt_w) begin
            nxt_r = '0;
            nxt_w = '0;
        end
        case ({push_ok, pop_ok})
            2'b10:   delta = CW'(1);
            2'b01:   delta = {CW{1'b1}};
            default: delta = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (req.load_sts) begin
            mem[0] <= req.sts;
            mem[1] <= MSG_FILL;
        end else if (push_ok) begin
            mem[wr_ptr] <= req.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            residual <= '0;
            rd_byte  <= '0;
        end else if (req.clear) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            residual <= '0;
        end else if (req.load_sts) begin
            rd_ptr   <= '0;
            wr_ptr   <= PW'(2);
            residual <= CW'(2);
        end else begin
            rd_ptr   <= nxt_r;
            wr_ptr   <= nxt_w;
            residual <= residual + delta;
            if (pop_ok)
                rd_byte <= mem[rd_ptr];
            else if (req.zero_rd)
                rd_byte <= '0;
        end
    end

    assert_ptr_order_R4: assert property (@(posedge clk) disable iff (rst)
        rd_ptr <= wr_ptr);

    assert_meet_snaps_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_ptr == wr_ptr) |-> (wr_ptr == '0));

    assert_count_tracks_R1: assert property (@(posedge clk) disable iff (rst)
        residual == {2'b00, PW'(wr_ptr - rd_ptr)});

    assert_limit_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (req.push && wr_ptr == PW'(DEPTH - 1) && !req.pop && !req.clear && !req.load_sts)
        |=> ($stable(wr_ptr) && $stable(residual)));

    assert_zero_read_R3: assert property (@(posedge clk) disable iff (rst)
        (req.zero_rd && !req.clear && !req.load_sts)
        |=> (rd_byte == '0 && $stable(rd_ptr)));

    assert_status_load_R6: assert property (@(posedge clk) disable iff (rst)
        (req.load_sts && !req.clear)
        |=> (wr_ptr == PW'(2) && rd_ptr == '0 && residual == CW'(2)));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        req.clear |=> (residual == '0 && wr_ptr == '0 && rd_ptr == '0));

endmodule

// File: rtl/pcf_cmd_buf.sv
module pcf_cmd_buf
    import pcf_pkg::*;
#(
    parameter int CMD_DEPTH = 32,
    localparam int LW = $clog2(CMD_DEPTH + 1),
    localparam int IW = $clog2(CMD_DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          push,
    input  byte_t         wdata,
    input  logic [IW-1:0] rd_idx,
    output logic [LW-1:0] cmd_len,
    output byte_t         rd_byte,
    output logic          drop
);

    byte_t mem [CMD_DEPTH];
    logic  accept;

    always_comb begin
        accept  = push && !clear && (cmd_len != LW'(CMD_DEPTH));
        drop    = push && !clear && !accept;
        rd_byte = mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (accept)
            mem[cmd_len[IW-1:0]] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            cmd_len <= '0;
        else if (accept)
            cmd_len <= cmd_len + LW'(1);
    end

    assert_cmd_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_len <= LW'(CMD_DEPTH));

    assert_cmd_full_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (push && !clear && cmd_len == LW'(CMD_DEPTH)) |=> (cmd_len == LW'(CMD_DEPTH)));

    assert_cmd_grow_R8: assert property (@(posedge clk) disable iff (rst)
        (push && !clear && cmd_len != LW'(CMD_DEPTH))
        |=> (cmd_len == $past(cmd_len) + LW'(1)));

endmodule

// File: rtl/pio_fifo_cmdcap.sv
module pio_fifo_cmdcap
    import pcf_pkg::*;
#(
    parameter int BUF_DEPTH = 16,
    parameter int CMD_DEPTH = 32,
    localparam int PW = $clog2(BUF_DEPTH),
    localparam int CW = PW + 2,
    localparam int LW = $clog2(CMD_DEPTH + 1),
    localparam int IW = $clog2(CMD_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [7:0]           wr_data,
    input  logic                 rd_en,
    input  logic [2:0]           bus_phase,
    input  logic                 capture_mode,
    input  logic                 sel_start,
    input  logic                 status_load,
    input  logic [7:0]           status_byte,
    input  logic                 flush,
    input  logic [IW-1:0]        cmd_rd_idx,
    output logic [7:0]           rd_data,
    output logic signed [CW-1:0] residual,
    output logic [PW:0]          fill_level,
    output logic                 overrun,
    output logic [LW-1:0]        cmd_len,
    output logic [7:0]           cmd_rd_data
);

    fifo_req_t     req;
    logic          busy_ctl;
    logic          cmd_push;
    logic          fifo_drop, cmd_drop;
    logic [PW-1:0] rd_ptr, wr_ptr;

    always_comb begin
        busy_ctl     = sel_start || status_load;
        req.clear    = sel_start;
        req.load_sts = status_load && !sel_start;
        req.push     = wr_en && !capture_mode && !busy_ctl;
        req.pop      = rd_en && !phase_is_out(bus_phase) && !busy_ctl;
        req.zero_rd  = rd_en && phase_is_out(bus_phase) && !busy_ctl;
        req.wdata    = wr_data;
        req.sts      = status_byte;
        cmd_push     = wr_en && capture_mode && !busy_ctl;
        fill_level   = {1'b0, wr_ptr} - {1'b0, rd_ptr};
    end

    pcf_data_fifo #(.DEPTH(BUF_DEPTH)) u_data (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .rd_byte  (rd_data),
        .rd_ptr   (rd_ptr),
        .wr_ptr   (wr_ptr),
        .residual (residual),
        .drop     (fifo_drop)
    );

    pcf_cmd_buf #(.CMD_DEPTH(CMD_DEPTH)) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .clear   (sel_start),
        .push    (cmd_push),
        .wdata   (wr_data),
        .rd_idx  (cmd_rd_idx),
        .cmd_len (cmd_len),
        .rd_byte (cmd_rd_data),
        .drop    (cmd_drop)
    );

    always_ff @(posedge clk) begin
        if (rst)
            overrun <= 1'b0;
        else if (fifo_drop || cmd_drop)
            overrun <= 1'b1;
        else if (flush)
            overrun <= 1'b0;
    end

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (overrun && !flush) |=> overrun);

    assert_drop_flags_R2: assert property (@(posedge clk) disable iff (rst)
        (fifo_drop || cmd_drop) |=> overrun);

    assert_capture_keeps_queue_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_push && !rd_en) |=> $stable(residual));

endmodule

// File: tb/test_pio_fifo_cmdcap.sv
module test_pio_fifo_cmdcap;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 0, rd_en = 0, capture_mode = 0;
    logic              sel_start = 0, status_load = 0, flush = 0;
    logic [7:0]        wr_data = 0, status_byte = 0;
    logic [2:0]        bus_phase = 3'b001;
    logic [4:0]        cmd_rd_idx = 0;
    logic [7:0]        rd_data, cmd_rd_data;
    logic signed [5:0] residual;
    logic [4:0]        fill_level;
    logic              overrun;
    logic [5:0]        cmd_len;

    int n_chk = 0, n_fail = 0;
    bit chk_now = 0, done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;  // 250 MHz

    pio_fifo_cmdcap i_pio_fifo_cmdcap (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .bus_phase(bus_phase), .capture_mode(capture_mode), .sel_start(sel_start),
        .status_load(status_load), .status_byte(status_byte), .flush(flush),
        .cmd_rd_idx(cmd_rd_idx), .rd_data(rd_data), .residual(residual),
        .fill_level(fill_level), .overrun(overrun), .cmd_len(cmd_len),
        .cmd_rd_data(cmd_rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // driver: one write
    task automatic do_write(input logic [7:0] b);
        wr_en = 1; wr_data = b;
        cyc();
        wr_en = 0;
    endtask

    // driver: one read, expected byte handed to the scoreboard
    task automatic do_read(input logic [7:0] exp_v, input string tag);
        rd_en = 1;
        cyc();
        rd_en = 0;
        exp_q.push_back(exp_v);
        tag_q.push_back(tag);
        chk_now = 1;
    endtask

    // monitor: compares the read result away from the edge
    always @(negedge clk) begin
        if (chk_now) begin
            chk_now = 0;
            check(tag_q.pop_front(), int'(rd_data), int'(exp_q.pop_front()));
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R11 reset state
        check("R11 residual", int'(residual), 0);
        check("R11 fill", int'(fill_level), 0);
        check("R11 overrun", int'(overrun), 0);
        check("R11 cmd_len", int'(cmd_len), 0);
        check("R11 rd_data", int'(rd_data), 0);

        // R1 writes and R4 ordered reads
        do_write(8'hA1); do_write(8'hA2); do_write(8'hA3);
        check("R1 residual", int'(residual), 3);
        check("R1 fill", int'(fill_level), 3);
        do_read(8'hA1, "R4 first byte");
        wr_en = 1; wr_data = 8'hB4; rd_en = 1;
        cyc();
        wr_en = 0; rd_en = 0;
        exp_q.push_back(8'hA2); tag_q.push_back("R1 read with write"); chk_now = 1;
        check("R1 residual same-cycle", int'(residual), 2);
        do_read(8'hA3, "R4 third byte");
        do_read(8'hB4, "R1 byte written with read");
        check("R4 residual drained", int'(residual), 0);
        do_read(8'hB4, "R4 empty read keeps data");
        check("R4 empty residual", int'(residual), 0);

        // R3 data-out read
        do_write(8'hC0);
        bus_phase = 3'b000;
        do_read(8'h00, "R3 zero read");
        bus_phase = 3'b001;
        check("R3 no pop", int'(residual), 1);
        do_read(8'hC0, "R3 byte still there");

        // R2 limit, R5 snap, R10 sticky
        for (int i = 0; i < 15; i++) do_write(8'h40 + 8'(i));
        check("R2 residual full", int'(residual), 15);
        check("R2 no overrun yet", int'(overrun), 0);
        do_write(8'hFF);
        check("R2 residual held", int'(residual), 15);
        check("R2 overrun", int'(overrun), 1);
        for (int i = 0; i < 15; i++) do_read(8'h40 + 8'(i), "R2 order");
        check("R5 drained", int'(residual), 0);
        repeat (3) cyc();
        check("R10 sticky", int'(overrun), 1);
        flush = 1; cyc(); flush = 0;
        check("R10 flush clears", int'(overrun), 0);
        for (int i = 0; i < 15; i++) do_write(8'h60 + 8'(i));
        check("R5 refill no overrun", int'(overrun), 0);
        check("R5 refill fill", int'(fill_level), 15);
        flush = 1; wr_en = 1; wr_data = 8'h77;
        cyc();
        flush = 0; wr_en = 0;
        check("R10 drop with flush", int'(overrun), 1);
        flush = 1; cyc(); flush = 0;
        check("R10 flush alone", int'(overrun), 0);

        // R7 selection clear
        sel_start = 1; wr_en = 1; wr_data = 8'h55; rd_en = 1;
        cyc();
        sel_start = 0; wr_en = 0; rd_en = 0;
        check("R7 residual", int'(residual), 0);
        check("R7 fill", int'(fill_level), 0);
        check("R7 read ignored", int'(rd_data), 8'h4E);
        do_write(8'hD5);
        do_read(8'hD5, "R7 after clear");

        // R6 status preload
        status_byte = 8'h02; status_load = 1; wr_en = 1; wr_data = 8'hEE;
        cyc();
        status_load = 0; wr_en = 0;
        check("R6 residual", int'(residual), 2);
        check("R6 fill", int'(fill_level), 2);
        do_read(8'h02, "R6 status byte");
        do_read(8'h00, "R6 message byte");
        check("R6 drained", int'(residual), 0);

        // R8 capture, R9 full
        capture_mode = 1;
        do_write(8'h12); do_write(8'h34);
        check("R8 cmd_len", int'(cmd_len), 2);
        check("R8 queue untouched", int'(residual), 0);
        cmd_rd_idx = 0; #0;
        check("R8 cmd byte 0", int'(cmd_rd_data), 8'h12);
        cmd_rd_idx = 1; #0;
        check("R8 cmd byte 1", int'(cmd_rd_data), 8'h34);
        for (int i = 2; i < 32; i++) do_write(8'hA0 + 8'(i));
        check("R9 cmd full", int'(cmd_len), 32);
        check("R9 no overrun yet", int'(overrun), 0);
        do_write(8'h99);
        check("R9 cmd_len held", int'(cmd_len), 32);
        check("R9 overrun", int'(overrun), 1);
        cmd_rd_idx = 31; #0;
        check("R9 last byte kept", int'(cmd_rd_data), 8'hBF);
        sel_start = 1; cyc(); sel_start = 0;
        check("R7 cmd_len cleared", int'(cmd_len), 0);
        capture_mode = 0;

        // R11 reset clears sticky flag
        do_write(8'h01);
        rst = 1; cyc(); rst = 0; cyc();
        check("R11 overrun after reset", int'(overrun), 0);
        check("R11 residual after reset", int'(residual), 0);

        cyc(); cyc();
        done = 1;
        report();
        $finish;
    end

endmodule